// File: doc/BRIEF.md
# SHA-256 Streaming Hash Engine

This block computes a SHA-256 digest over a message that arrives as already-padded 32-bit words. A padding stage ahead of it hands over each 512-bit block as sixteen words through a request/acknowledge handshake. The engine runs one compression round per clock cycle. The first sixteen rounds consume the incoming words as they arrive, so there is no separate load phase. After each block's 64 rounds, the working variables are folded into the chaining state.

A message starts with an `init` pulse, which loads the standard initial hash values. The padding stage marks the final block by holding `lastBlk` high with that block's sixteenth word. When that block completes, `ready` rises and the eight chaining words appear on `digest`. They stay there until the next `init`. A global enable `en` freezes every register, and an active-low reset clears the control state asynchronously.

Top module: `sha256_stream`

## Requirements
- R1: While `rstN` is low, `req` and `ready` are 0 without waiting for a clock edge. After reset the engine stays idle, with `req` at 0, until `init`.
- R2: A cycle with `en` and `init` both high loads the standard initial hash values and drops any block in progress. `req` is 1 and `ready` is 0 from the next cycle on.
- R3: A word on `wordIn` is captured on a rising edge only when `en`, `req` and `ack` are all 1. Words and `lastBlk` values presented while `req` is 0 have no effect on the digest.
- R4: While `req` is 1 and `ack` is 0, the engine stalls. `req` stays 1 and no round advances.
- R5: `req` falls after the sixteenth word of a block is captured. For a block that is not the last, `req` rises again exactly 49 cycles after that capture edge.
- R6: While `en` is 0, no register changes, including the round counter and the handshake state. Every cycle with `en` low lengthens a block by one cycle.
- R7: The engine computes the SHA-256 compression over each block and adds the working variables modulo 2^32 into the chaining state. `digest` carries H0 in bits 255:224, down to H7 in bits 31:0.
- R8: `lastBlk` is sampled with the sixteenth word of a block. When it is 1, `ready` rises 49 cycles after that capture instead of `req`.
- R9: Once `ready` is 1, it stays 1 and `digest` stays unchanged until the next `init`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rstN | input | 1 | Asynchronous active-low reset |
| en | input | 1 | Global enable; 0 freezes all registers |
| init | input | 1 | Starts a new message |
| ack | input | 1 | Source acknowledges a word request |
| wordIn | input | 32 | Padded message word |
| lastBlk | input | 1 | Marks the current block as final, sampled with its 16th word |
| req | output | 1 | Engine requests a word |
| ready | output | 1 | Digest is valid |
| digest | output | 256 | Chaining state H0..H7, H0 in the top bits |

## Verification
The bench hashes known messages of one and two blocks and compares each result against its published digest. It stalls with `ack` low on some words and freezes `en` both during word intake and during the round tail. A design that advanced a round during a stall, or captured a word twice across a freeze, would give a wrong digest. The bench also counts cycles from the sixteenth capture to the next `req` or `ready` edge. An off-by-one in the round counter or in the final addition would show up as 48 or 50 instead of 49. Junk words and a high `lastBlk` are driven while `req` is low to expose capture outside a request. Finally, the bench restarts a message mid-block and checks that `ready` holds across idle cycles.

// File: rtl/sha256_pkg.sv
package sha256_pkg;
  localparam int WORD_W      = 32;
  localparam int BLOCK_WORDS = 16;
  localparam int ROUNDS      = 64;
  localparam int STATE_WORDS = 8;
  localparam int CNT_W       = $clog2(ROUNDS);
  localparam int DIGEST_W    = WORD_W * STATE_WORDS;

  typedef logic [WORD_W-1:0] word_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_LOAD, ST_RUN, ST_FINAL, ST_DONE
  } phase_t;

  typedef struct packed {
    logic             initLoad;
    logic             roundStep;
    logic             useInput;
    logic             finalAdd;
    logic [CNT_W-1:0] roundIdx;
  } ctrlStb_t;

  localparam word_t ROUND_K [ROUNDS] = '{
    32'h428a2f98, 32'h71374491, 32'hb5c0fbcf, 32'he9b5dba5,
    32'h3956c25b, 32'h59f111f1, 32'h923f82a4, 32'hab1c5ed5,
    32'hd807aa98, 32'h12835b01, 32'h243185be, 32'h550c7dc3,
    32'h72be5d74, 32'h80deb1fe, 32'h9bdc06a7, 32'hc19bf174,
    32'he49b69c1, 32'hefbe4786, 32'h0fc19dc6, 32'h240ca1cc,
    32'h2de92c6f, 32'h4a7484aa, 32'h5cb0a9dc, 32'h76f988da,
    32'h983e5152, 32'ha831c66d, 32'hb00327c8, 32'hbf597fc7,
    32'hc6e00bf3, 32'hd5a79147, 32'h06ca6351, 32'h14292967,
    32'h27b70a85, 32'h2e1b2138, 32'h4d2c6dfc, 32'h53380d13,
    32'h650a7354, 32'h766a0abb, 32'h81c2c92e, 32'h92722c85,
    32'ha2bfe8a1, 32'ha81a664b, 32'hc24b8b70, 32'hc76c51a3,
    32'hd192e819, 32'hd6990624, 32'hf40e3585, 32'h106aa070,
    32'h19a4c116, 32'h1e376c08, 32'h2748774c, 32'h34b0bcb5,
    32'h391c0cb3, 32'h4ed8aa4a, 32'h5b9cca4f, 32'h682e6ff3,
    32'h748f82ee, 32'h78a5636f, 32'h84c87814, 32'h8cc70208,
    32'h90befffa, 32'ha4506ceb, 32'hbef9a3f7, 32'hc67178f2
  };

  localparam word_t INIT_H [STATE_WORDS] = '{
    32'h6a09e667, 32'hbb67ae85, 32'h3c6ef372, 32'ha54ff53a,
    32'h510e527f, 32'h9b05688c, 32'h1f83d9ab, 32'h5be0cd19
  };

  function automatic word_t rotr(input word_t x, input int n);
    return (x >> n) | (x << (WORD_W - n));
  endfunction

  function automatic word_t bigSig0(input word_t x);
    return rotr(x, 2) ^ rotr(x, 13) ^ rotr(x, 22);
  endfunction

  function automatic word_t bigSig1(input word_t x);
    return rotr(x, 6) ^ rotr(x, 11) ^ rotr(x, 25);
  endfunction

  function automatic word_t smallSig0(input word_t x);
    return rotr(x, 7) ^ rotr(x, 18) ^ (x >> 3);
  endfunction

  function automatic word_t smallSig1(input word_t x);
    return rotr(x, 17) ^ rotr(x, 19) ^ (x >> 10);
  endfunction

  function automatic word_t chooseFn(input word_t e, input word_t f, input word_t g);
    return (e & f) ^ (~e & g);
  endfunction

  function automatic word_t majFn(input word_t a, input word_t b, input word_t c);
    return (a & b) ^ (a & c) ^ (b & c);
  endfunction
endpackage

// File: rtl/sha256_ctrl.sv
module sha256_ctrl
  import sha256_pkg::*;
(
  input  logic     clk,
  input  logic     rstN,
  input  logic     en,
  input  logic     init,
  input  logic     ack,
  input  logic     lastBlk,
  output logic     req,
  output logic     ready,
  output ctrlStb_t stb
);
  localparam logic [CNT_W-1:0] LAST_LOAD  = CNT_W'(BLOCK_WORDS - 1);
  localparam logic [CNT_W-1:0] LAST_ROUND = CNT_W'(ROUNDS - 1);

  phase_t           phase;
  logic [CNT_W-1:0] roundCnt;
  logic             lastQ;

  assign req   = (phase == ST_LOAD);
  assign ready = (phase == ST_DONE);

  always_comb begin
    stb           = '0;
    stb.initLoad  = en && init;
    stb.useInput  = (phase == ST_LOAD);
    stb.roundIdx  = roundCnt;
    stb.roundStep = en && !init &&
                    (((phase == ST_LOAD) && ack) || (phase == ST_RUN));
    stb.finalAdd  = en && !init && (phase == ST_FINAL);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase    <= ST_IDLE;
      roundCnt <= '0;
      lastQ    <= 1'b0;
    end else if (en) begin
      if (init) begin
        phase    <= ST_LOAD;
        roundCnt <= '0;
        lastQ    <= 1'b0;
      end else begin
        unique case (phase)
          ST_LOAD: begin
            if (ack) begin
              roundCnt <= roundCnt + 1'b1;
              if (roundCnt == LAST_LOAD) begin
                phase <= ST_RUN;
                lastQ <= lastBlk;
              end
            end
          end
          ST_RUN: begin
            roundCnt <= roundCnt + 1'b1;
            if (roundCnt == LAST_ROUND) phase <= ST_FINAL;
          end
          ST_FINAL: begin
            roundCnt <= '0;
            phase    <= lastQ ? ST_DONE : ST_LOAD;
          end
          default: ;
        endcase
      end
    end
  end

  // R4: a pending request without acknowledge holds the round position
  a_r4_stall_hold: assert property (@(posedge clk) disable iff (!rstN)
    (en && !init && req && !ack) |=> (req && $stable(roundCnt)));

  // R5: the sixteenth capture withdraws the request
  a_r5_req_drop: assert property (@(posedge clk) disable iff (!rstN)
    (en && !init && req && ack && roundCnt == LAST_LOAD) |=> !req);

  // R6: enable low freezes the control registers
  a_r6_freeze: assert property (@(posedge clk) disable iff (!rstN)
    !en |=> ($stable(phase) && $stable(roundCnt) && $stable(lastQ)));

  // R9: ready holds until a new message starts
  a_r9_ready_hold: assert property (@(posedge clk) disable iff (!rstN)
    (ready && !(en && init)) |=> ready);

  // R2: init restarts intake on the next cycle
  a_r2_init_restart: assert property (@(posedge clk) disable iff (!rstN)
    (en && init) |=> (req && !ready));
endmodule

// File: rtl/sha256_datapath.sv
module sha256_datapath
  import sha256_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  ctrlStb_t            stb,
  input  word_t               wordIn,
  output logic [DIGEST_W-1:0] digest
);
  localparam int W_M2  = BLOCK_WORDS - 2;
  localparam int W_M7  = BLOCK_WORDS - 7;
  localparam int W_M15 = BLOCK_WORDS - 15;
  localparam int W_M16 = BLOCK_WORDS - 16;

  logic [STATE_WORDS-1:0][WORD_W-1:0] chainH;
  logic [STATE_WORDS-1:0][WORD_W-1:0] work;
  logic [BLOCK_WORDS-1:0][WORD_W-1:0] sched;

  word_t schedNext, curW, temp1, temp2;

  always_comb begin
    schedNext = smallSig1(sched[W_M2]) + sched[W_M7]
              + smallSig0(sched[W_M15]) + sched[W_M16];
    curW  = stb.useInput ? wordIn : schedNext;
    temp1 = work[7] + bigSig1(work[4]) + chooseFn(work[4], work[5], work[6])
          + ROUND_K[stb.roundIdx] + curW;
    temp2 = bigSig0(work[0]) + majFn(work[0], work[1], work[2]);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      chainH <= '0;
      work   <= '0;
      sched  <= '0;
    end else if (stb.initLoad) begin
      for (int i = 0; i < STATE_WORDS; i++) begin
        chainH[i] <= INIT_H[i];
        work[i]   <= INIT_H[i];
      end
    end else if (stb.finalAdd) begin
      for (int i = 0; i < STATE_WORDS; i++) begin
        chainH[i] <= chainH[i] + work[i];
        work[i]   <= chainH[i] + work[i];
      end
    end else if (stb.roundStep) begin
      work[0] <= temp1 + temp2;
      work[1] <= work[0];
      work[2] <= work[1];
      work[3] <= work[2];
      work[4] <= work[3] + temp1;
      work[5] <= work[4];
      work[6] <= work[5];
      work[7] <= work[6];
      for (int i = 0; i < BLOCK_WORDS - 1; i++) sched[i] <= sched[i + 1];
      sched[BLOCK_WORDS-1] <= curW;
    end
  end

  for (genvar gi = 0; gi < STATE_WORDS; gi++) begin : g_digest
    assign digest[DIGEST_W-1-WORD_W*gi -: WORD_W] = chainH[gi];
  end

  // R9: chaining state changes only on init or a block's final addition
  a_r9_chain_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!stb.initLoad && !stb.finalAdd) |=> $stable(chainH));

  // R4: without a round step the working variables and schedule hold
  a_r4_work_hold: assert property (@(posedge clk) disable iff (!rstN)
    (!stb.initLoad && !stb.finalAdd && !stb.roundStep) |=> ($stable(work) && $stable(sched)));
endmodule

// File: rtl/sha256_stream.sv
module sha256_stream
  import sha256_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  logic                en,
  input  logic                init,
  input  logic                ack,
  input  logic [WORD_W-1:0]   wordIn,
  input  logic                lastBlk,
  output logic                req,
  output logic                ready,
  output logic [DIGEST_W-1:0] digest
);
  ctrlStb_t stb;

  sha256_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .en      (en),
    .init    (init),
    .ack     (ack),
    .lastBlk (lastBlk),
    .req     (req),
    .ready   (ready),
    .stb     (stb)
  );

  sha256_datapath u_dp (
    .clk    (clk),
    .rstN   (rstN),
    .stb    (stb),
    .wordIn (wordIn),
    .digest (digest)
  );
endmodule

// File: tb/sha256_stream_bench.sv
`timescale 1ns/1ps
module sha256_stream_bench;
  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         en = 1'b1;
  logic         init = 1'b0;
  logic         ack = 1'b0;
  logic [31:0]  wordIn = '0;
  logic         lastBlk = 1'b0;
  logic         req, ready;
  logic [255:0] digest;

  int testCnt = 0;
  int failCnt = 0;
  int cycCnt  = 0;
  logic [31:0] msg [32];

  localparam logic [255:0] DIG_ABC =
    256'hba7816bf8f01cfea414140de5dae2223b00361a396177a9cb410ff61f20015ad;
  localparam logic [255:0] DIG_EMPTY =
    256'he3b0c44298fc1c149afbf4c8996fb92427ae41e4649b934ca495991b7852b855;
  localparam logic [255:0] DIG_TWO =
    256'h248d6a61d20638b8e5c026930c3e6039a33ce45964ff2167f6ecedd419db06c1;

  always #5 clk = ~clk;

  sha256_stream u_sha256_stream (
    .clk(clk), .rstN(rstN), .en(en), .init(init), .ack(ack),
    .wordIn(wordIn), .lastBlk(lastBlk), .req(req), .ready(ready), .digest(digest)
  );

  always @(posedge clk) begin
    cycCnt <= cycCnt + 1;
    if (cycCnt == 150000) begin
      failCnt = failCnt + 1;
      testCnt = testCnt + 1;
      $display("FAIL watchdog: run hung, act=%0d cycles exp=<150000", cycCnt);
      $display("  [TB] %0d tests run, %0d failed", testCnt, failCnt);
      $finish;
    end
  end

  task automatic check(input bit ok, input string tag, input logic [255:0] act,
                       input logic [255:0] exp);
    testCnt++;
    if (!ok) begin
      failCnt++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic loadAbc();
    for (int i = 0; i < 32; i++) msg[i] = '0;
    msg[0] = 32'h61626380;
    msg[15] = 32'h00000018;
  endtask

  task automatic loadEmpty();
    for (int i = 0; i < 32; i++) msg[i] = '0;
    msg[0] = 32'h80000000;
  endtask

  task automatic loadTwo();
    for (int i = 0; i < 32; i++) msg[i] = '0;
    for (int i = 0; i < 14; i++) begin
      logic [7:0] c;
      c = 8'h61 + 8'(i);
      msg[i] = {c, c + 8'd1, c + 8'd2, c + 8'd3};
    end
    msg[14] = 32'h80000000;
    msg[31] = 32'h000001c0;
  endtask

  // called at a negedge; returns at the negedge after the capture edge
  task automatic putWord(input logic [31:0] w, input bit lastF, input int stallCyc,
                         input int freezeCyc);
    while (!req) @(negedge clk);
    ack = 1'b0;
    for (int s = 0; s < stallCyc; s++) begin
      wordIn = 32'hbad0_0000 | 32'(s);
      @(negedge clk);
      check(req == 1'b1, "R4 req held during stall", 256'(req), 256'd1);
    end
    wordIn = w; lastBlk = lastF; ack = 1'b1;
    if (freezeCyc > 0) begin
      en = 1'b0;
      repeat (freezeCyc) @(negedge clk);
      en = 1'b1;
    end
    @(negedge clk);
    ack = 1'b0; wordIn = 32'hdeadbeef; lastBlk = 1'b0;
  endtask

  task automatic pulseInit();
    @(negedge clk);
    init = 1'b1;
    @(negedge clk);
    init = 1'b0;
    check(req == 1'b1 && ready == 1'b0, "R2 request after init", 256'({req, ready}), 256'b10);
  endtask

  task automatic runMessage(input int nb, input bit stall, input bit loadFreeze,
                            input bit tailFreeze, input logic [255:0] exp, input string tag);
    pulseInit();
    for (int b = 0; b < nb; b++) begin
      int k;
      int expK;
      bit isLast;
      isLast = (b == nb - 1);
      for (int i = 0; i < 16; i++)
        putWord(msg[b*16+i], isLast && i == 15, stall ? (i % 3) : 0,
                (loadFreeze && i == 5) ? 3 : 0);
      check(req == 1'b0, "R5 req drops after 16 words", 256'(req), 256'd0);
      // junk offered while req is low must be ignored (R3); lastBlk junk too
      ack = 1'b1; wordIn = 32'h0badf00d; lastBlk = 1'b1;
      k = 0;
      expK = 49 + ((tailFreeze && b == 0) ? 7 : 0);
      while (!(req || ready)) begin
        if (tailFreeze && b == 0 && k == 10) begin
          en = 1'b0;
          repeat (7) begin @(negedge clk); k++; end
          en = 1'b1;
        end else begin
          @(negedge clk);
          k++;
        end
        if (k > 200) break;
      end
      ack = 1'b0; lastBlk = 1'b0;
      if (isLast)
        check(ready && !req && k == expK, {tag, " R8 ready delay"}, 256'(k), 256'(expK));
      else
        check(req && !ready && k == expK, {tag, " R5/R6 req delay"}, 256'(k), 256'(expK));
    end
    check(digest == exp, {tag, " R7 digest"}, digest, exp);
  endtask

  initial begin
    #23;
    check(req == 1'b0 && ready == 1'b0, "R1 reset outputs", 256'({req, ready}), 256'd0);
    @(negedge clk);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    check(req == 1'b0 && ready == 1'b0, "R1 idle before init", 256'({req, ready}), 256'd0);

    loadAbc();
    runMessage(1, 1'b0, 1'b0, 1'b0, DIG_ABC, "abc");

    // R9: ready and digest hold through idle cycles, with junk on the inputs
    ack = 1'b1; wordIn = 32'h12345678; lastBlk = 1'b1;
    repeat (40) @(negedge clk);
    ack = 1'b0; lastBlk = 1'b0;
    check(ready == 1'b1, "R9 ready holds", 256'(ready), 256'd1);
    check(digest == DIG_ABC, "R9 digest holds", digest, DIG_ABC);

    // R6 + R4: two blocks with stalls, freeze during intake and tail
    loadTwo();
    runMessage(2, 1'b1, 1'b1, 1'b1, DIG_TWO, "two-stall");

    // two blocks without disturbance: tail exactly 49 (R5)
    runMessage(2, 1'b0, 1'b0, 1'b0, DIG_TWO, "two-clean");

    // empty message with stalls
    loadEmpty();
    runMessage(1, 1'b1, 1'b0, 1'b0, DIG_EMPTY, "empty");

    // R2: restart in the middle of a block
    pulseInit();
    for (int i = 0; i < 5; i++) putWord(32'hffff0000 + 32'(i), 1'b0, 0, 0);
    loadAbc();
    runMessage(1, 1'b0, 1'b0, 1'b0, DIG_ABC, "R2 restart");

    // R1: asynchronous reset mid-block
    pulseInit();
    for (int i = 0; i < 16; i++) putWord(msg[i], 1'b0, 0, 0);
    repeat (5) @(negedge clk);
    #2 rstN = 1'b0;
    #1;
    check(req == 1'b0 && ready == 1'b0, "R1 async reset", 256'({req, ready}), 256'd0);
    @(negedge clk);
    rstN = 1'b1;
    repeat (60) @(negedge clk);
    check(req == 1'b0 && ready == 1'b0, "R1 idle after reset", 256'({req, ready}), 256'd0);

    // after reset the engine still works
    runMessage(1, 1'b0, 1'b0, 1'b0, DIG_ABC, "post-reset");

    $display("  [TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end
endmodule